// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Target Receiver

This block is the receiving end of an I2C bus for a peripheral that is only ever written to. A fast system clock samples SCL and SDA. The block finds START and STOP conditions and shifts in the address byte. It answers only to one fixed 7-bit address, and only when the transfer direction is write.

After such an address, every complete byte that follows is acknowledged. The block also hands that byte to a downstream command/data consumer, together with a single-cycle valid strobe. The block never places data on the bus. Its only output to the bus is a pull-low request, `sda_pull_o`, and the pad logic turns that request into an open-drain SDA driver. The block drives it only during acknowledge slots.

A repeated START discards any partially received byte and begins a new address phase. A STOP returns the block to idle.

Top module: `tw_write_target`

## Requirements
- R1: While reset is high and in the cycle after it, `sda_pull_o` and `rx_valid_o` are 0.
- R2: SDA is sampled on each rising edge of SCL, and bits are assembled most significant first. START is SDA falling while SCL is high. STOP is SDA rising while SCL is high.
- R3: An address byte whose upper seven bits equal 0111110 and whose last bit (the R/W bit) is 0 is acknowledged. The block pulls SDA low from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock. The pull is never started while SCL is high.
- R4: An address byte whose upper seven bits differ from 0111110 gets no acknowledge. Every byte after it, up to the next START, is neither acknowledged nor presented on `rx_valid_o`.
- R5: A matching address with R/W bit 1 (a read request) gets no acknowledge. Every byte after it, up to the next START, is ignored.
- R6: After an acknowledged address, each complete 8-bit data byte is acknowledged. The byte appears on `rx_byte_o` while `rx_valid_o` is high for exactly one cycle, and that cycle coincides with the first cycle of the acknowledge pull.
- R7: A START in the middle of a byte aborts that byte without presenting it, releases SDA, and restarts address reception.
- R8: A STOP releases SDA in the next cycle and returns the block to idle. Bits clocked after a STOP and before the next START are neither acknowledged nor presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 requests that the pad pull SDA low (acknowledge) |
| rx_byte_o | output | BYTE_W | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new byte on `rx_byte_o` |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser, 8-bit bytes and target address 0111110. It drives the bus as an open-drain model, with each SCL phase lasting twenty system clocks. That is long enough that the three-cycle detection latency never overlaps an SDA change, so the acknowledge window and release timing can be observed directly on the wired bus. It also means that addresses one bit away from 0111110 and the read direction can be shown to be refused. The defaults also allow a repeated START to be placed after three bits of a data byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] pipe;

  // Lines idle high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], line_i};
  end

  assign line_o = pipe[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Conditions qualify on SCL high in both the old and new sample.
  assign start_o = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q &  sda_s;
  assign rise_o  =  scl_s & ~scl_q;
  assign fall_o  = ~scl_s &  scl_q;
endmodule

// File: rtl/tw_rx_engine.sv
module tw_rx_engine
  import tw_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int unsigned DEV_ADDR = 7'b0111110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              pull_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

  rx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              addr_hit;

  assign addr_hit = (sh[BYTE_W-1:1] == MY_ADDR) && !sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      pull_o  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else if (stop_i) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_DATA: begin
            if (rise_i && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  pull_o <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else begin
                pull_o  <= 1'b1;
                data_o  <= sh;
                valid_o <= 1'b1;
                st      <= ST_DACK;
              end
            end
          end
          ST_AACK, ST_DACK: begin
            if (fall_i) begin
              pull_o <= 1'b0;
              st     <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_write_target.sv
module tw_write_target #(
  parameter int          SYNC_STAGES = 2,
  parameter int          BYTE_W      = 8,
  parameter int unsigned DEV_ADDR    = 7'b0111110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);
  logic scl_s, sda_s;
  logic start_p, stop_p, rise_p, fall_p;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i), .line_o(scl_s)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i), .line_o(sda_s)
  );

  tw_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_o(start_p), .stop_o(stop_p), .rise_o(rise_p), .fall_o(fall_p)
  );

  tw_rx_engine #(.BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s),
    .start_i(start_p), .stop_i(stop_p), .rise_i(rise_p), .fall_i(fall_p),
    .pull_o(sda_pull_o), .data_o(rx_byte_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/tw_write_target_chk.sv
module tw_write_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_p,
  input logic stop_p,
  input logic sda_pull,
  input logic rx_valid
);
  // R6: strobe lasts one cycle
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: strobe coincides with the acknowledge pull
  assert_valid_with_ack_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sda_pull);

  // R3: pull never begins while the synchronised clock is high
  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R7: START releases the line
  assert_start_release_R7: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !sda_pull);

  // R8: STOP releases the line
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_pull);
endmodule

bind tw_write_target tw_write_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_p(start_p),
  .stop_p(stop_p), .sda_pull(sda_pull_o), .rx_valid(rx_valid_o)
);

// File: tb/sim_tw_write_target.sv
module sim_tw_write_target;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       sda_bus;

  int errors = 0;
  int checks = 0;
  int cap_n  = 0;
  int dbl    = 0;
  logic [7:0] cap [8];
  logic prev_vld = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  tw_write_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        cap[cap_n % 8] <= rx_byte;
        cap_n <= cap_n + 1;
        if (prev_vld) dbl <= dbl + 1;
      end
      prev_vld <= rx_valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic bus_bit(input bit b);
    sda_m = b;    wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_byte(input logic [7:0] d, output bit acked);
    for (int i = 7; i >= 0; i--) bus_bit(d[i]);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    acked = !sda_bus;
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic t_reset;
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    chk(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
  endtask

  task automatic t_write;
    bit a; int base = cap_n;
    bus_start();
    bus_byte(8'h7C, a); chk(a, "R3 address ack", a, 1);
    bus_byte(8'hA5, a); chk(a, "R6 ack byte A5", a, 1);
    bus_byte(8'h3C, a); chk(a, "R6 ack byte 3C", a, 1);
    bus_byte(8'h80, a); chk(a, "R6 ack byte 80", a, 1);
    bus_byte(8'h01, a); chk(a, "R6 ack byte 01", a, 1);
    bus_stop(); wq(1);
    chk(cap_n - base == 4, "R6 byte count", cap_n - base, 4);
    chk(cap[base % 8] == 8'hA5, "R2 msb first A5", cap[base % 8], 8'hA5);
    chk(cap[(base+1) % 8] == 8'h3C, "R6 byte 3C", cap[(base+1) % 8], 8'h3C);
    chk(cap[(base+2) % 8] == 8'h80, "R2 msb bit 80", cap[(base+2) % 8], 8'h80);
    chk(cap[(base+3) % 8] == 8'h01, "R2 lsb bit 01", cap[(base+3) % 8], 8'h01);
    chk(sda_pull == 1'b0, "R8 released after stop", sda_pull, 0);
  endtask

  task automatic t_wrong_addr;
    bit a; int base = cap_n;
    bus_start();
    bus_byte(8'h7E, a); chk(!a, "R4 no ack 0111111", a, 0);
    bus_byte(8'h55, a); chk(!a, "R4 no ack data", a, 0);
    bus_stop();
    bus_start();
    bus_byte(8'h3C, a); chk(!a, "R4 no ack 0011110", a, 0);
    bus_stop(); wq(1);
    chk(cap_n == base, "R4 nothing presented", cap_n - base, 0);
  endtask

  task automatic t_read_dir;
    bit a; int base = cap_n;
    bus_start();
    bus_byte(8'h7D, a); chk(!a, "R5 no ack read", a, 0);
    bus_byte(8'h99, a); chk(!a, "R5 no ack after read", a, 0);
    bus_stop(); wq(1);
    chk(cap_n == base, "R5 nothing presented", cap_n - base, 0);
  endtask

  task automatic t_restart;
    bit a; int base = cap_n;
    bus_start();
    bus_byte(8'h7C, a); chk(a, "R7 first address ack", a, 1);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start();
    chk(sda_pull == 1'b0, "R7 released at restart", sda_pull, 0);
    bus_byte(8'h7C, a); chk(a, "R7 second address ack", a, 1);
    bus_byte(8'h81, a); chk(a, "R7 ack after restart", a, 1);
    bus_stop(); wq(1);
    chk(cap_n - base == 1, "R7 partial dropped", cap_n - base, 1);
    chk(cap[base % 8] == 8'h81, "R7 byte after restart", cap[base % 8], 8'h81);
  endtask

  task automatic t_after_stop;
    bit a; int base = cap_n;
    bus_start();
    bus_byte(8'h7C, a); chk(a, "R8 address ack", a, 1);
    bus_stop();
    scl_m = 1'b0; wq(1);
    bus_byte(8'hC3, a); chk(!a, "R8 no ack after stop", a, 0);
    bus_byte(8'h7C, a); chk(!a, "R8 no address without start", a, 0);
    scl_m = 1'b1; wq(1);
    bus_stop(); wq(1);
    chk(cap_n == base, "R8 nothing presented", cap_n - base, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    wq(2);
    t_write();
    t_wrong_addr();
    t_read_dir();
    t_restart();
    t_after_stop();
    chk(dbl == 0, "R6 valid never two cycles", dbl, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule